// File: doc/BRIEF.md
# Warm-White Two-Channel PWM Mixer

This block drives two LED strings, one white and one red, from a single free-running period counter. Two stored settings shape the light. The first is a brightness level. The second is a mix value that moves the output from white toward red. Each channel has a compare threshold, which is the level multiplied by a weight taken from the mix. The red weight is the mix itself, and the white weight is its complement. Raising the level therefore scales both channels together. Moving the mix shifts light between the channels and leaves the level untouched.

The settings are adjusted from pushbuttons that are already debounced. One button selects the level and the other selects the mix. A direction switch chooses whether the selected setting steps up or down. The buttons are sampled only on the clock edge where the counter rolls over to zero, so each setting lasts at least one full PWM period. The widths of the settings and of the counter are parameters, and so are the reset values of the settings.

Top module: `warm_pwm_mixer`

## Requirements
- R1: A synchronous active-high reset clears the period counter, loads level = 8 and mix = 8, and drives both outputs low.
- R2: The 8-bit period counter counts 0 to 255 and wraps. Each output is registered. In every period it is high for exactly as many cycles as its threshold, starting in the cycle after the counter reads 0. In the cycle after the counter reads 255 it is low.
- R3: The red threshold equals level × mix. The white threshold equals level × (15 − mix). Both settings are 4-bit values.
- R4: When only `adj_level_btn` is pressed, the level steps and the mix is unchanged. When only `adj_mix_btn` is pressed, the mix steps and the level is unchanged. `dir_up` = 1 steps up and `dir_up` = 0 steps down.
- R5: When both buttons are pressed, or neither is, both settings stay unchanged.
- R6: Buttons are sampled only at the edge where the counter goes from 255 to 0. A press held for a whole period makes exactly one step. A press that starts and ends inside one period, with no wrap edge in between, has no effect.
- R7: Stepping saturates. An increment at 15 stays at 15 and a decrement at 0 stays at 0.
- R8: A channel whose threshold is 0 stays low for the whole period. With level 0, both outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adj_level_btn | input | 1 | Selects the brightness level for adjustment |
| adj_mix_btn | input | 1 | Selects the white/red mix for adjustment |
| dir_up | input | 1 | 1 = step up, 0 = step down |
| white_pwm | output | 1 | PWM drive for the white string |
| red_pwm | output | 1 | PWM drive for the red string |

## Verification
The hardest behaviour to reach from the ports is the once-per-period rule. The settings can only be observed through duty cycles, and those are measured over whole periods. The stimulus holds each button combination for exactly 256 cycles, which always covers exactly one wrap edge. It then counts high cycles over the next full period and compares the count with the threshold predicted for a single step. A design that updates on every cycle would saturate and show a different count. A second directed case presses a button only in mid-period, using a cycle count kept by the bench, and shows that nothing changes.

// File: rtl/wm_pkg.sv
package wm_pkg;
   // channel indices into the threshold vector
   localparam int CH_WHITE = 0;
   localparam int CH_RED   = 1;
   localparam int CH_N     = 2;

   typedef enum logic [1:0] {
      ADJ_NONE  = 2'd0,
      ADJ_LEVEL = 2'd1,
      ADJ_MIX   = 2'd2
   } adj_sel_e;
endpackage

// File: rtl/wm_period_ctr.sv
module wm_period_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_LAST = '1;

   always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt + 1'b1;
   end

   // high on the edge that takes the counter back to zero
   assign wrap = (cnt == CNT_LAST);
endmodule

// File: rtl/wm_adjust.sv
module wm_adjust
   import wm_pkg::*;
#(
   parameter int LVL_W      = 4,
   parameter int LEVEL_INIT = 8,
   parameter int MIX_INIT   = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wrap,
   input  logic             btn_level,
   input  logic             btn_mix,
   input  logic             dir_up,
   output logic [LVL_W-1:0] level,
   output logic [LVL_W-1:0] mix
);
   localparam logic [LVL_W-1:0] LVL_TOP = '1;
   localparam logic [LVL_W-1:0] LVL_RST = LVL_W'(LEVEL_INIT);
   localparam logic [LVL_W-1:0] MIX_RST = LVL_W'(MIX_INIT);

   adj_sel_e         sel;
   logic [LVL_W-1:0] level_nx;
   logic [LVL_W-1:0] mix_nx;

   function automatic logic [LVL_W-1:0] sat_step(input logic [LVL_W-1:0] v,
                                                 input logic up);
      if (up) return (v == LVL_TOP) ? v : v + 1'b1;
      else    return (v == '0)      ? v : v - 1'b1;
   endfunction

   // exactly one button selects a target; both or none select nothing
   always_comb begin
      unique case ({btn_level, btn_mix})
         2'b10:   sel = ADJ_LEVEL;
         2'b01:   sel = ADJ_MIX;
         default: sel = ADJ_NONE;
      endcase
   end

   always_comb begin
      level_nx = level;
      mix_nx   = mix;
      if (wrap) begin
         case (sel)
            ADJ_LEVEL: level_nx = sat_step(level, dir_up);
            ADJ_MIX:   mix_nx   = sat_step(mix, dir_up);
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         level <= LVL_RST;
         mix   <= MIX_RST;
      end else begin
         level <= level_nx;
         mix   <= mix_nx;
      end
   end
endmodule

// File: rtl/wm_thresh.sv
module wm_thresh
   import wm_pkg::*;
#(
   parameter int LVL_W = 4,
   parameter int CNT_W = 8
) (
   input  logic [LVL_W-1:0]            level,
   input  logic [LVL_W-1:0]            mix,
   output logic [CH_N-1:0][CNT_W-1:0]  thr
);
   localparam int               PROD_W  = 2 * LVL_W;
   localparam logic [LVL_W-1:0] LVL_TOP = '1;

   for (genvar c = 0; c < CH_N; c++) begin : g_ch
      logic [LVL_W-1:0]  weight;
      logic [PROD_W-1:0] prod;
      if (c == CH_RED) begin : g_red
         assign weight = mix;
      end else begin : g_white
         assign weight = LVL_TOP - mix;
      end
      assign prod   = PROD_W'(level) * PROD_W'(weight);
      assign thr[c] = CNT_W'(prod);
   end
endmodule

// File: rtl/wm_pwm_chan.sv
module wm_pwm_chan #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] thr,
   output logic             pwm
);
   // high from the cycle after count 0 for thr cycles
   always_ff @(posedge clk) begin
      if (rst) pwm <= 1'b0;
      else     pwm <= (cnt < thr);
   end
endmodule

// File: rtl/warm_pwm_mixer.sv
module warm_pwm_mixer
   import wm_pkg::*;
#(
   parameter int LVL_W      = 4,
   parameter int CNT_W      = 8,
   parameter int LEVEL_INIT = 8,
   parameter int MIX_INIT   = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic adj_level_btn,
   input  logic adj_mix_btn,
   input  logic dir_up,
   output logic white_pwm,
   output logic red_pwm
);
   localparam int PROD_W  = 2 * LVL_W;
   localparam int LVL_MAX = (1 << LVL_W) - 1;

   if (LVL_W < 1) begin : g_bad_lvl
      $error("warm_pwm_mixer: LVL_W must be positive");
   end
   if (PROD_W > CNT_W) begin : g_bad_cnt
      $error("warm_pwm_mixer: counter too narrow for level x weight");
   end
   if (LEVEL_INIT < 0 || LEVEL_INIT > LVL_MAX || MIX_INIT < 0 || MIX_INIT > LVL_MAX) begin : g_bad_init
      $error("warm_pwm_mixer: reset settings out of range");
   end

   logic [CNT_W-1:0]           cnt;
   logic                       wrap;
   logic [LVL_W-1:0]           level;
   logic [LVL_W-1:0]           mix;
   logic [CH_N-1:0][CNT_W-1:0] thr;
   logic [CH_N-1:0]            pwm;

   wm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .cnt  (cnt),
      .wrap (wrap)
   );

   wm_adjust #(
      .LVL_W      (LVL_W),
      .LEVEL_INIT (LEVEL_INIT),
      .MIX_INIT   (MIX_INIT)
   ) u_adj (
      .clk       (clk),
      .rst       (rst),
      .wrap      (wrap),
      .btn_level (adj_level_btn),
      .btn_mix   (adj_mix_btn),
      .dir_up    (dir_up),
      .level     (level),
      .mix       (mix)
   );

   wm_thresh #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_thr (
      .level (level),
      .mix   (mix),
      .thr   (thr)
   );

   for (genvar c = 0; c < CH_N; c++) begin : g_pwm
      wm_pwm_chan #(.CNT_W(CNT_W)) u_ch (
         .clk (clk),
         .rst (rst),
         .cnt (cnt),
         .thr (thr[c]),
         .pwm (pwm[c])
      );
   end

   assign white_pwm = pwm[CH_WHITE];
   assign red_pwm   = pwm[CH_RED];
endmodule

// File: rtl/wm_checker.sv
module wm_checker #(
   parameter int LVL_W      = 4,
   parameter int CNT_W      = 8,
   parameter int LEVEL_INIT = 8,
   parameter int MIX_INIT   = 8
) (
   input logic             clk,
   input logic             rst,
   input logic [CNT_W-1:0] cnt,
   input logic [LVL_W-1:0] level,
   input logic [LVL_W-1:0] mix,
   input logic             btn_level,
   input logic             btn_mix,
   input logic             dir_up,
   input logic             white_pwm,
   input logic             red_pwm
);
   localparam logic [CNT_W-1:0] LAST = '1;
   localparam logic [LVL_W-1:0] TOP  = '1;

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (cnt == '0 && level == LVL_W'(LEVEL_INIT) && mix == LVL_W'(MIX_INIT)
               && !white_pwm && !red_pwm));

   assert_low_after_wrap_R2: assert property (@(posedge clk) disable iff (rst)
      (cnt == LAST) |=> (!white_pwm && !red_pwm));

   assert_mix_kept_R4: assert property (@(posedge clk) disable iff (rst)
      (btn_level && !btn_mix) |=> $stable(mix));

   assert_level_kept_R4: assert property (@(posedge clk) disable iff (rst)
      (btn_mix && !btn_level) |=> $stable(level));

   assert_both_or_none_R5: assert property (@(posedge clk) disable iff (rst)
      (btn_level == btn_mix) |=> ($stable(level) && $stable(mix)));

   assert_hold_mid_period_R6: assert property (@(posedge clk) disable iff (rst)
      (cnt != LAST) |=> ($stable(level) && $stable(mix)));

   assert_sat_top_R7: assert property (@(posedge clk) disable iff (rst)
      (cnt == LAST && btn_level && !btn_mix && dir_up && level == TOP) |=> (level == TOP));

   assert_sat_bottom_R7: assert property (@(posedge clk) disable iff (rst)
      (cnt == LAST && btn_mix && !btn_level && !dir_up && mix == '0) |=> (mix == '0));

   assert_dark_at_zero_R8: assert property (@(posedge clk) disable iff (rst)
      (level == '0) |=> (!white_pwm && !red_pwm));
endmodule

bind warm_pwm_mixer wm_checker #(
   .LVL_W      (LVL_W),
   .CNT_W      (CNT_W),
   .LEVEL_INIT (LEVEL_INIT),
   .MIX_INIT   (MIX_INIT)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cnt       (cnt),
   .level     (level),
   .mix       (mix),
   .btn_level (adj_level_btn),
   .btn_mix   (adj_mix_btn),
   .dir_up    (dir_up),
   .white_pwm (white_pwm),
   .red_pwm   (red_pwm)
);

// File: tb/sim_warm_pwm_mixer.sv
`timescale 1ns/1ps
module sim_warm_pwm_mixer;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic adj_level_btn = 1'b0;
   logic adj_mix_btn   = 1'b0;
   logic dir_up        = 1'b0;
   logic white_pwm;
   logic red_pwm;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;
   logic [7:0] ph = '0;   // bench's own period phase

   always #2 clk = ~clk;  // 250 MHz

   always @(posedge clk) ph <= rst ? 8'd0 : ph + 8'd1;

   warm_pwm_mixer u0 (
      .clk           (clk),
      .rst           (rst),
      .adj_level_btn (adj_level_btn),
      .adj_mix_btn   (adj_mix_btn),
      .dir_up        (dir_up),
      .white_pwm     (white_pwm),
      .red_pwm       (red_pwm)
   );

   // {level btn, mix btn, dir_up, expected red highs, expected white highs}
   localparam int NV = 8;
   localparam logic [18:0] VEC [NV] = '{
      {3'b101, 8'd72, 8'd63},   // R4 level 9, mix 8
      {3'b101, 8'd80, 8'd70},   // R4 level 10
      {3'b011, 8'd90, 8'd60},   // R4 mix 9
      {3'b111, 8'd90, 8'd60},   // R5 both pressed
      {3'b000, 8'd90, 8'd60},   // R5 none pressed
      {3'b010, 8'd80, 8'd70},   // R4 mix down to 8
      {3'b100, 8'd72, 8'd63},   // R4 level down to 9
      {3'b110, 8'd72, 8'd63}    // R5 both pressed, down
   };

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // hold a button combination for exactly one full period (one wrap edge)
   task automatic hold_period(input logic bl, input logic bm, input logic up);
      @(negedge clk);
      adj_level_btn = bl; adj_mix_btn = bm; dir_up = up;
      repeat (256) @(negedge clk);
      adj_level_btn = 1'b0; adj_mix_btn = 1'b0;
   endtask

   task automatic measure(input string req, input int exp_r, input int exp_w);
      int cr = 0;
      int cw = 0;
      repeat (256) begin
         @(negedge clk);
         cr += int'(red_pwm);
         cw += int'(white_pwm);
      end
      check({req, " red"}, cr, exp_r);
      check({req, " white"}, cw, exp_w);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 red low in reset", int'(red_pwm), 0);
      check("R1 white low in reset", int'(white_pwm), 0);
      rst = 1'b0;
   endtask

   initial begin
      do_reset();
      // first edge after release: counter 0 -> 1, outputs turn on
      @(negedge clk);
      check("R2 red high after count 0", int'(red_pwm), 1);
      check("R2 white high after count 0", int'(white_pwm), 1);
      // run to the end of the period and check the low phase after count 255
      while (ph != 8'd0) @(negedge clk);
      check("R2 red low after count 255", int'(red_pwm), 0);
      measure("R1 R3 reset settings", 64, 56);

      for (int k = 0; k < NV; k++) begin
         hold_period(VEC[k][18], VEC[k][17], VEC[k][16]);
         measure($sformatf("R3 vector %0d", k), int'(VEC[k][15:8]), int'(VEC[k][7:0]));
      end

      // R6: press only mid-period, no wrap edge covered
      while (ph != 8'd10) @(negedge clk);
      adj_level_btn = 1'b1; dir_up = 1'b1;
      repeat (100) @(negedge clk);
      adj_level_btn = 1'b0;
      measure("R6 mid-period press ignored", 72, 63);

      // R6/R7: seven full-period presses take level 9 -> 15 and saturate
      for (int k = 0; k < 7; k++) hold_period(1'b1, 1'b0, 1'b1);
      measure("R7 level saturates at 15", 120, 105);

      // R7/R8: mix down past 0
      for (int k = 0; k < 9; k++) hold_period(1'b0, 1'b1, 1'b0);
      measure("R8 mix 0 red dark", 0, 225);

      // R8: level to 0, then mix up to 15 (level stays 0)
      for (int k = 0; k < 16; k++) hold_period(1'b1, 1'b0, 1'b0);
      measure("R8 level 0 both dark", 0, 0);
      for (int k = 0; k < 16; k++) hold_period(1'b0, 1'b1, 1'b1);
      measure("R4 R8 mix 15 level 0 dark", 0, 0);
      hold_period(1'b1, 1'b0, 1'b1);
      measure("R8 mix 15 white dark", 15, 0);

      // R1: reset mid-run restores defaults
      do_reset();
      measure("R1 reset restores settings", 64, 56);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule